// File: doc/BRIEF.md
# Host Initialization Timeout Monitor

This block is a hardware supervisor on the host side of a port's status/address (SA) register and its initialize (IP) register. When `start` is asserted, it issues a hard-initialize write to IP. It then follows the four-step initialization handshake by sampling SA. At each step it writes the configured host word, and it checks the fields the port echoes back against what was written earlier. Each wait has a fixed deadline. After any port interrupt, the monitor waits a settling interval before it trusts SA again. The result is reported as pass or fail, with a failure code and the step in which the failure happened.

If the step-1 word requests wrap-test mode, the monitor clears the interrupt-enable bit in that word. It then runs an echo loop instead of steps 2 to 4: the monitor writes a pattern, waits for SA to read back the same value, and moves on to the next pattern. All time limits are counted in microseconds. A prescaler derives the microsecond tick from the parameter `CLK_PER_US`, so a bench can use very short limits.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for `start`.
- `ST_HINIT`: pulses `ip_wr`.
- `ST_WAIT`: waits for the next step flag to rise.
- `ST_WRITE`: writes the host word for the step that has begun.
- `ST_WRAP_WAIT`: waits for the echo of the current pattern.
- `ST_WRAP_WR`: writes the next pattern.
- `ST_RUNWAIT`: step 4, waiting for the port to start operating.
- `ST_PASS` and `ST_FAIL`: hold the result. `start` from either of them begins a new hard initialize.

The transitions are:
- IDLE→HINIT on `start`.
- HINIT→WAIT unconditionally.
- WAIT→WRITE when the expected flag (1 to 3) rises and its echo is correct.
- WAIT→RUNWAIT when flag 4 rises.
- WAIT→FAIL on the error flag, an out-of-order flag, an echo mismatch or a deadline expiry.
- WRITE→WAIT in normal mode.
- WRITE→WRAP_WAIT when a wrap test is requested.
- WRAP_WAIT→WRAP_WR on a match.
- WRAP_WAIT→PASS on the last match.
- WRAP_WAIT→FAIL at the deadline.
- RUNWAIT→PASS on `op_started`.
- RUNWAIT→FAIL on `hl_timer_done`.

Top module: `hinit_monitor`

## Requirements
- R1: On `start` in ST_IDLE, ST_PASS or ST_FAIL, `ip_wr` is high for exactly one cycle. On the next sample after that, `busy` is 1 and `fail_code` is 0.
- R2: SA layout:
  - Bit 15 is the error flag.
  - Bits 11, 12, 13 and 14 are the flags for steps 1, 2, 3 and 4.
  - A step begins when its flag rises between two accepted SA samples.
  - On the rise of flag 1, the monitor writes the step-1 word; on flag 2 it writes `cfg_step2`; on flag 3 it writes `cfg_step3`. Each write is a one-cycle `sa_wr` pulse.
- R3: Echo checks:
  - When flag 2 rises, SA[5:0] must equal bits 13:8 of the step-1 word as written.
  - When flag 3 rises, SA[7:0] must equal bits 7:0 of that word.
  - A mismatch gives `fail_code` 3, with `fail_step` 2 or 3 respectively.
- R4: If the next flag has not risen within STEP_LIMIT_US microseconds of the hard initialize or of the last write, the result is `fail_code` 1. `fail_step` is the step in progress, which is the number of the expected flag minus one.
- R5: For SETTLE_US microseconds after a cycle with `dev_irq` high, the monitor accepts no SA sample. This includes the interrupt cycle itself.
- R6: An accepted SA sample with bit 15 set during ST_WAIT gives `fail_code` 2, and `fail_step` is the step in progress.
- R7: A rising flag other than the expected one gives `fail_code` 4, and `fail_step` is the step in progress.
- R8: After flag 4 rises, the monitor passes only on `op_started`. If `hl_timer_done` arrives first, the result is `fail_code` 5 with `fail_step` 4.
- R9: Wrap-test mode:
  - Bit 14 of `cfg_step1` requests a wrap test, and bit 7 of that word is interrupt enable. In wrap-test mode the written step-1 word has bit 7 cleared.
  - Pattern k is the written step-1 word plus k·WRAP_STRIDE (modulo 2^16), for k = 0 to WRAP_PATTERNS−1.
  - When SA equals the full current pattern, the next pattern is written. The last match gives pass. Bit 15 is ignored in this mode.
  - A missing echo at the deadline gives `fail_code` 1 with `fail_step` 1.
- R10: After reset, `busy`, `done_pass`, `done_fail`, `ip_wr` and `sa_wr` are all 0, and so is `fail_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new hard initialize |
| cfg_step1 | input | 16 | Host word for step 1 (bit 14 wrap request, bit 7 interrupt enable) |
| cfg_step2 | input | 16 | Host word for step 2 |
| cfg_step3 | input | 16 | Host word for step 3 |
| sa_rdata | input | 16 | Current SA read value |
| dev_irq | input | 1 | Port interrupt, one or more cycles |
| op_started | input | 1 | Port has begun normal operation |
| hl_timer_done | input | 1 | Higher-level step-4 timer expired |
| ip_wr | output | 1 | Hard-initialize write strobe |
| sa_wr | output | 1 | SA write strobe |
| sa_wdata | output | 16 | SA write data |
| busy | output | 1 | Handshake in progress |
| done_pass | output | 1 | Handshake finished successfully |
| done_fail | output | 1 | Handshake aborted |
| fail_code | output | 3 | 1 timeout, 2 error flag, 3 echo, 4 order, 5 step-4 timer |
| fail_step | output | 3 | Step in which the failure occurred |

## Verification
The bench runs these scenarios:
- **Clean handshakes.** Step words are swept across several values, with and without interrupts. Some echo fields are all-ones and some near-zero, so a check that compares the wrong bit range shows up.
- **Single-fault handshakes.** Each one injects exactly one fault: a wrong echo at step 2, a wrong echo at step 3, the error flag, a skipped flag, a silent port, or an expired step-4 timer. Each fault maps to one failure code and step, which separates the detection paths from one another.
- **Settling test.** An interrupt arrives with a transient error flag that clears inside the settling window. This tells a monitor that honours the window apart from one that samples early.
- **Wrap tests.** One run echoes every pattern, including a pattern whose top bit is set. Another run stops echoing partway. Together they check the pattern arithmetic, the cleared interrupt-enable bit and the wrap deadline.

// File: rtl/hinit_mon_pkg.sv
package hinit_mon_pkg;

    localparam int SA_W      = 16;
    localparam int ER_BIT    = 15;
    localparam int FLAG_LO   = 11;
    localparam int N_FLAGS   = 4;
    localparam int WRAP_BIT  = 14;
    localparam int IE_BIT    = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HINIT,
        ST_WAIT,
        ST_WRITE,
        ST_WRAP_WAIT,
        ST_WRAP_WR,
        ST_RUNWAIT,
        ST_PASS,
        ST_FAIL
    } mon_state_e;

    typedef enum logic [2:0] {
        FC_NONE     = 3'd0,
        FC_TIMEOUT  = 3'd1,
        FC_ERFLAG   = 3'd2,
        FC_ECHO     = 3'd3,
        FC_ORDER    = 3'd4,
        FC_LATE_RUN = 3'd5
    } fail_code_e;

endpackage

// File: rtl/hinit_us_timer.sv
// Microsecond interval timer: a cycle prescaler feeding a saturating
// microsecond counter. Cleared by clr, advances while run is high.
module hinit_us_timer #(
    parameter int CLK_PER_US    = 100,
    parameter int LIMIT_US      = 100,
    parameter bit RESET_EXPIRED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam int CW = $clog2(LIMIT_US + 1);
    localparam logic [PW-1:0] PRE_TOP = PW'(CLK_PER_US - 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(LIMIT_US);

    logic [PW-1:0] pre_q;
    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q == CNT_TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= RESET_EXPIRED ? CNT_TOP : '0;
        end else if (clr) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (run && !expired) begin
            if (pre_q == PRE_TOP) begin
                pre_q <= '0;
                cnt_q <= cnt_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hinit_seq_fsm.sv
// Handshake sequencer: step tracking, echo comparison, wrap loop, result.
module hinit_seq_fsm
    import hinit_mon_pkg::*;
#(
    parameter int                 WRAP_PATTERNS = 8,
    parameter logic [SA_W-1:0]    WRAP_STRIDE   = 16'h1357
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [SA_W-1:0] cfg_step1,
    input  logic [SA_W-1:0] cfg_step2,
    input  logic [SA_W-1:0] cfg_step3,
    input  logic [SA_W-1:0] sa_in,
    input  logic            sample_ok,
    input  logic            step_expired,
    input  logic            op_started,
    input  logic            hl_timer_done,
    output logic            step_clr,
    output logic            step_run,
    output logic            ip_wr,
    output logic            sa_wr,
    output logic [SA_W-1:0] sa_wdata,
    output logic            busy,
    output logic            done_pass,
    output logic            done_fail,
    output logic [2:0]      fail_code,
    output logic [2:0]      fail_step
);
    localparam int PCW = (WRAP_PATTERNS > 2) ? $clog2(WRAP_PATTERNS) : 1;
    localparam logic [PCW-1:0] PAT_LAST = PCW'(WRAP_PATTERNS - 1);

    mon_state_e           state, nstate;
    fail_code_e           fcode_q, nfc;
    logic [2:0]           fstep_q, nfs;
    logic [2:0]           exp_q;
    logic [N_FLAGS-1:0]   prev_q, cur_flags, rise, exp_oh;
    logic [SA_W-1:0]      pat_q, word1;
    logic [PCW-1:0]       pcnt_q;
    logic                 wrap_q, cur_er, wrap_req;

    assign cur_flags = sa_in[FLAG_LO +: N_FLAGS];
    assign cur_er    = sa_in[ER_BIT];
    assign rise      = cur_flags & ~prev_q;
    assign exp_oh    = N_FLAGS'(1) << (exp_q - 3'd1);
    assign wrap_req  = cfg_step1[WRAP_BIT];

    always_comb begin
        word1 = cfg_step1;
        if (wrap_req) word1[IE_BIT] = 1'b0;
    end

    // next state and failure cause
    always_comb begin
        nstate = state;
        nfc    = FC_NONE;
        nfs    = exp_q - 3'd1;
        unique case (state)
            ST_IDLE:  if (start) nstate = ST_HINIT;
            ST_HINIT: nstate = ST_WAIT;
            ST_WAIT: begin
                if (sample_ok && cur_er) begin
                    nstate = ST_FAIL; nfc = FC_ERFLAG;
                end else if (sample_ok && (rise != '0)) begin
                    if (rise != exp_oh) begin
                        nstate = ST_FAIL; nfc = FC_ORDER;
                    end else if (exp_q == 3'd2 && sa_in[5:0] != word1[13:8]) begin
                        nstate = ST_FAIL; nfc = FC_ECHO; nfs = 3'd2;
                    end else if (exp_q == 3'd3 && sa_in[7:0] != word1[7:0]) begin
                        nstate = ST_FAIL; nfc = FC_ECHO; nfs = 3'd3;
                    end else if (exp_q == 3'd4) begin
                        nstate = ST_RUNWAIT;
                    end else begin
                        nstate = ST_WRITE;
                    end
                end else if (step_expired) begin
                    nstate = ST_FAIL; nfc = FC_TIMEOUT;
                end
            end
            ST_WRITE: nstate = (exp_q == 3'd1 && wrap_req) ? ST_WRAP_WAIT : ST_WAIT;
            ST_WRAP_WAIT: begin
                if (sample_ok && sa_in == pat_q) begin
                    nstate = (pcnt_q == PAT_LAST) ? ST_PASS : ST_WRAP_WR;
                end else if (step_expired) begin
                    nstate = ST_FAIL; nfc = FC_TIMEOUT; nfs = 3'd1;
                end
            end
            ST_WRAP_WR: nstate = ST_WRAP_WAIT;
            ST_RUNWAIT: begin
                if (op_started) begin
                    nstate = ST_PASS;
                end else if (hl_timer_done) begin
                    nstate = ST_FAIL; nfc = FC_LATE_RUN; nfs = 3'd4;
                end
            end
            ST_PASS, ST_FAIL: if (start) nstate = ST_HINIT;
            default: nstate = ST_IDLE;
        endcase
    end

    // state register and sequencing data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            exp_q   <= 3'd1;
            prev_q  <= '0;
            pat_q   <= '0;
            pcnt_q  <= '0;
            wrap_q  <= 1'b0;
            fcode_q <= FC_NONE;
            fstep_q <= '0;
        end else begin
            state <= nstate;
            if (nstate == ST_HINIT) begin
                exp_q   <= 3'd1;
                prev_q  <= '0;
                pcnt_q  <= '0;
                wrap_q  <= 1'b0;
                fcode_q <= FC_NONE;
                fstep_q <= '0;
            end
            if (state == ST_WAIT && sample_ok && !cur_er) prev_q <= cur_flags;
            if (state == ST_WRITE) begin
                if (exp_q == 3'd1 && wrap_req) begin
                    wrap_q <= 1'b1;
                    pat_q  <= word1;
                end else begin
                    exp_q <= exp_q + 3'd1;
                end
            end
            if (state == ST_WRAP_WAIT && nstate == ST_WRAP_WR) begin
                pcnt_q <= pcnt_q + 1'b1;
                pat_q  <= pat_q + WRAP_STRIDE;
            end
            if (nstate == ST_FAIL && state != ST_FAIL) begin
                fcode_q <= nfc;
                fstep_q <= nfs;
            end
        end
    end

    // Moore outputs
    always_comb begin
        ip_wr     = (state == ST_HINIT);
        sa_wr     = (state == ST_WRITE) || (state == ST_WRAP_WR);
        step_clr  = (state == ST_HINIT) || sa_wr;
        step_run  = (state == ST_WAIT) || (state == ST_WRAP_WAIT);
        busy      = !(state == ST_IDLE || state == ST_PASS || state == ST_FAIL);
        done_pass = (state == ST_PASS);
        done_fail = (state == ST_FAIL);
        fail_code = fcode_q;
        fail_step = fstep_q;
        sa_wdata  = '0;
        if (state == ST_WRAP_WR) begin
            sa_wdata = pat_q;
        end else if (state == ST_WRITE) begin
            unique case (exp_q)
                3'd1:    sa_wdata = word1;
                3'd2:    sa_wdata = cfg_step2;
                default: sa_wdata = cfg_step3;
            endcase
        end
    end

    // R1
    ip_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ip_wr |=> !ip_wr);
    // R3
    echo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_fail) && fail_code == FC_ECHO) |-> (fail_step == 3'd2 || fail_step == 3'd3));
    // R4
    timeout_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_fail) && fail_code == FC_TIMEOUT) |-> $past(step_expired));
    // R6
    er_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_fail) && fail_code == FC_ERFLAG) |-> $past(sa_in[ER_BIT]));
    // R8
    pass_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_pass) && !wrap_q) |-> $past(op_started));
endmodule

// File: rtl/hinit_monitor.sv
module hinit_monitor
    import hinit_mon_pkg::*;
#(
    parameter int              CLK_PER_US    = 100,
    parameter int              STEP_LIMIT_US = 10_000_000,
    parameter int              SETTLE_US     = 100,
    parameter int              WRAP_PATTERNS = 8,
    parameter logic [15:0]     WRAP_STRIDE   = 16'h1357
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] cfg_step1,
    input  logic [15:0] cfg_step2,
    input  logic [15:0] cfg_step3,
    input  logic [15:0] sa_rdata,
    input  logic        dev_irq,
    input  logic        op_started,
    input  logic        hl_timer_done,
    output logic        ip_wr,
    output logic        sa_wr,
    output logic [15:0] sa_wdata,
    output logic        busy,
    output logic        done_pass,
    output logic        done_fail,
    output logic [2:0]  fail_code,
    output logic [2:0]  fail_step
);
    logic step_clr, step_run, step_expired, settle_done, sample_ok;

    assign sample_ok = settle_done && !dev_irq;

    hinit_us_timer #(
        .CLK_PER_US(CLK_PER_US), .LIMIT_US(STEP_LIMIT_US), .RESET_EXPIRED(1'b0)
    ) u_step_tmr (
        .clk(clk), .rst_n(rst_n), .clr(step_clr), .run(step_run), .expired(step_expired)
    );

    hinit_us_timer #(
        .CLK_PER_US(CLK_PER_US), .LIMIT_US(SETTLE_US), .RESET_EXPIRED(1'b1)
    ) u_settle_tmr (
        .clk(clk), .rst_n(rst_n), .clr(dev_irq), .run(1'b1), .expired(settle_done)
    );

    hinit_seq_fsm #(
        .WRAP_PATTERNS(WRAP_PATTERNS), .WRAP_STRIDE(WRAP_STRIDE)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_step1(cfg_step1), .cfg_step2(cfg_step2), .cfg_step3(cfg_step3),
        .sa_in(sa_rdata), .sample_ok(sample_ok), .step_expired(step_expired),
        .op_started(op_started), .hl_timer_done(hl_timer_done),
        .step_clr(step_clr), .step_run(step_run),
        .ip_wr(ip_wr), .sa_wr(sa_wr), .sa_wdata(sa_wdata),
        .busy(busy), .done_pass(done_pass), .done_fail(done_fail),
        .fail_code(fail_code), .fail_step(fail_step)
    );

    // R5
    settle_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_irq |=> !settle_done);
endmodule

// File: tb/hinit_monitor_tb.sv
module hinit_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] STRIDE = 16'h1357;
    localparam int NPAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cfg1 = '0, cfg2 = '0, cfg3 = '0;
    logic [15:0] sa = '0;
    logic        dev_irq = 1'b0, op_started = 1'b0, hl_done = 1'b0;
    logic        ip_wr, sa_wr, busy, done_pass, done_fail;
    logic [15:0] sa_wdata;
    logic [2:0]  fail_code, fail_step;

    int nchecks = 0;
    int nfails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hinit_monitor #(
        .CLK_PER_US(2), .STEP_LIMIT_US(20), .SETTLE_US(3),
        .WRAP_PATTERNS(NPAT), .WRAP_STRIDE(STRIDE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_step1(cfg1), .cfg_step2(cfg2), .cfg_step3(cfg3),
        .sa_rdata(sa), .dev_irq(dev_irq), .op_started(op_started),
        .hl_timer_done(hl_done), .ip_wr(ip_wr), .sa_wr(sa_wr),
        .sa_wdata(sa_wdata), .busy(busy), .done_pass(done_pass),
        .done_fail(done_fail), .fail_code(fail_code), .fail_step(fail_step)
    );

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int expv);
        nchecks++;
        if (!cond) begin
            nfails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dev_irq = 1'b0;
        end
    endtask

    task automatic wait_wr(output logic [15:0] d, output bit ok);
        ok = 1'b0;
        d  = '0;
        for (int i = 0; i < 100 && !ok; i++) begin
            tick(1);
            if (sa_wr) begin
                d  = sa_wdata;
                ok = 1'b1;
            end
        end
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 200 && !ok; i++) begin
            tick(1);
            if (done_pass || done_fail) ok = 1'b1;
        end
    endtask

    // hard initialize, raise flag 1, expect the step-1 word
    task automatic begin_init(input logic [15:0] w1_exp, input bit irq);
        logic [15:0] d;
        bit ok;
        start = 1'b1;
        tick(1);
        start = 1'b0;
        chk(ip_wr == 1'b1, "R1", "ip_wr pulse", ip_wr, 1);
        chk(busy == 1'b1 && fail_code == 3'd0, "R1", "busy/cleared code",
            {busy, fail_code}, 4'h8);
        sa = 16'h0800;
        dev_irq = irq;
        wait_wr(d, ok);
        chk(ok && d == w1_exp, "R2", "step1 word", d, w1_exp);
    endtask

    task automatic expect_fail(input string req, input int code, input int step);
        bit ok;
        wait_done(ok);
        chk(ok && done_fail && !done_pass, req, "fail flag", done_fail, 1);
        chk(fail_code == code[2:0] && fail_step == step[2:0], req, "code/step",
            {fail_code, fail_step}, {code[2:0], step[2:0]});
    endtask

    task automatic run_pass(input logic [15:0] w1, input logic [15:0] w2,
                            input logic [15:0] w3, input bit irq);
        logic [15:0] d;
        bit ok;
        cfg1 = w1; cfg2 = w2; cfg3 = w3;
        begin_init(w1, irq);
        sa = 16'h1800 | {10'd0, w1[13:8]};
        dev_irq = irq;
        wait_wr(d, ok);
        chk(ok && d == w2, "R3", "step2 word after good echo", d, w2);
        sa = 16'h3800 | {8'd0, w1[7:0]};
        dev_irq = irq;
        wait_wr(d, ok);
        chk(ok && d == w3, "R2", "step3 word", d, w3);
        sa = 16'h7800;
        dev_irq = irq;
        tick(10);
        chk(busy && !done_pass && !done_fail, "R8", "waits for run", busy, 1);
        op_started = 1'b1;
        tick(1);
        op_started = 1'b0;
        chk(done_pass && fail_code == 3'd0, "R8", "pass on op_started", done_pass, 1);
    endtask

    initial begin
        logic [15:0] d;
        logic [15:0] w;
        logic [15:0] e;
        bit ok;

        tick(3);
        chk(!busy && !done_pass && !done_fail && !ip_wr && !sa_wr && fail_code == 0,
            "R10", "reset state", {busy, done_pass, done_fail, ip_wr, sa_wr}, 0);
        rst_n = 1'b1;
        tick(2);
        chk(!busy && !ip_wr && !sa_wr, "R10", "idle after reset", busy, 0);

        // clean handshakes over a sweep of words
        for (int i = 0; i < 4; i++) begin
            case (i)
                0: w = 16'h0A05;
                1: w = 16'h15C3;
                2: w = 16'h3F80;
                default: w = 16'h0001;
            endcase
            run_pass(w, 16'h8000 | 16'(i), 16'(16'h0001 << i), i[0]);
        end

        // echo mismatch at step 2
        cfg1 = 16'h2A44;
        begin_init(16'h2A44, 1'b0);
        sa = 16'h1800 | {10'd0, cfg1[13:8] ^ 6'h01};
        expect_fail("R3", 3, 2);

        // echo mismatch at step 3
        begin_init(16'h2A44, 1'b0);
        sa = 16'h1800 | {10'd0, cfg1[13:8]};
        wait_wr(d, ok);
        chk(ok && d == cfg2, "R2", "step2 word", d, cfg2);
        sa = 16'h3800 | {8'd0, cfg1[7:0] ^ 8'h80};
        expect_fail("R3", 3, 3);

        // error flag during step 1
        begin_init(16'h2A44, 1'b0);
        sa = 16'h8800;
        expect_fail("R6", 2, 1);

        // flag 3 rises while flag 2 expected
        begin_init(16'h2A44, 1'b0);
        sa = 16'h2800;
        expect_fail("R7", 4, 1);

        // silent port: deadline 20 us * 2 cycles = 40 cycles after write
        begin_init(16'h2A44, 1'b0);
        tick(38);
        chk(!done_fail && busy, "R4", "no early timeout", done_fail, 0);
        tick(6);
        chk(done_fail && fail_code == 3'd1 && fail_step == 3'd1, "R4", "timeout step1",
            {done_fail, fail_code, fail_step}, {1'b1, 3'd1, 3'd1});

        // step-4 higher-level timer expiry
        begin_init(16'h2A44, 1'b0);
        sa = 16'h1800 | {10'd0, cfg1[13:8]};
        wait_wr(d, ok);
        sa = 16'h3800 | {8'd0, cfg1[7:0]};
        wait_wr(d, ok);
        chk(ok && d == cfg3, "R2", "step3 word", d, cfg3);
        sa = 16'h7800;
        tick(4);
        hl_done = 1'b1;
        tick(1);
        hl_done = 1'b0;
        chk(done_fail && fail_code == 3'd5 && fail_step == 3'd4, "R8", "step4 timer",
            {fail_code, fail_step}, {3'd5, 3'd4});

        // transient error flag inside the settling window is not seen
        begin_init(16'h2A44, 1'b0);
        sa = 16'h8800;
        dev_irq = 1'b1;
        tick(3);
        chk(!done_fail, "R5", "no sample during settle", done_fail, 0);
        sa = 16'h1800 | {10'd0, cfg1[13:8]};
        wait_wr(d, ok);
        chk(ok && d == cfg2 && !done_fail, "R5", "step2 after settle", d, cfg2);
        sa = 16'h3800 | {8'd0, cfg1[7:0]};
        wait_wr(d, ok);
        sa = 16'h7800;
        tick(4);
        op_started = 1'b1;
        tick(1);
        op_started = 1'b0;
        chk(done_pass, "R5", "pass after settle", done_pass, 1);

        // wrap test, all patterns echoed; IE bit cleared in step-1 word
        cfg1 = 16'h4AB5;
        begin_init(16'h4A35, 1'b0);
        sa = 16'h4A35;
        for (int k = 1; k < NPAT; k++) begin
            e = 16'h4A35 + 16'(k) * STRIDE;
            wait_wr(d, ok);
            chk(ok && d == e, "R9", "wrap pattern", d, e);
            sa = d;
        end
        tick(3);
        chk(done_pass && !done_fail, "R9", "wrap pass", done_pass, 1);

        // wrap test, second pattern never echoed
        begin_init(16'h4A35, 1'b0);
        sa = 16'h4A35;
        wait_wr(d, ok);
        e = 16'h4A35 + STRIDE;
        chk(ok && d == e, "R9", "wrap pattern 1", d, e);
        expect_fail("R9", 1, 1);

        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        nchecks++;
        nfails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
        $finish;
    end
endmodule